// File: doc/BRIEF.md
# Strided Window Address Generator

This block produces the byte address for every access of one port of a frame memory laid out as 8192 blocks of 64 bytes. In window mode it walks a rectangle: each row holds a programmed number of blocks, consecutive rows sit a signed number of blocks apart, and once the final row is finished the walk starts over at the window origin. A mirror bit makes each row run toward lower addresses. A negative row step makes the rows run toward lower addresses, which flips the picture vertically. With window mode off, the address is a plain linear counter.

The configuration inputs are captured only on a pointer-reset cycle. They can therefore change at any time without disturbing a walk that is in progress. The address moves only on cycles where the port enable is high. Beside the address, the block drives a commit qualifier that tells the memory whether the current enabled cycle really stores data. In window mode the freeze bit sets it. In linear mode the external mask sets it. A parameter builds a read-side variant instead: its row step is unsigned and it has no mirror and no freeze. The block has no data stream of its own: every pin is a plain level that is sampled on the rising clock edge, so there is no back-pressure to honour.

Top module: `strided_win_agen`

## Requirements
- R1: After the global reset `addr` is 0, window mode is off, and `commit` is low while `port_en` is low.
- R2: With window mode off, a pointer-reset cycle makes `addr` 0. After that, each cycle with `port_en` high adds 1 to `addr`, and `commit` equals `port_en` and not `hw_mask`.
- R3: `cfg_*` inputs are captured only on a cycle with `port_rst` high. Changing them on any other cycle has no effect on `addr` or `commit`.
- R4: A pointer-reset cycle in window mode sets `addr` to `cfg_start`×64, and `commit` is low on any cycle where `port_rst` is high.
- R5: With mirror off, a row covers `cfg_xsize`×64 bytes, and the address rises by 1 on each enabled cycle starting from the row base.
- R6: After the last byte of a row, the next address is the previous row base plus the row step×64. The row step is `cfg_stride`, a 13-bit two's-complement block count.
- R7: A negative row step places each following row lower in memory.
- R8: With mirror on, each row starts at its row base and the address falls by 1 on each enabled cycle for `cfg_xsize`×64 bytes.
- R9: After the last byte of row `cfg_ysize`-1, the address returns to `cfg_start`×64.
- R10: All address arithmetic wraps modulo 2^19.
- R11: In window mode `commit` is low while freeze is set and high while freeze is clear, whatever `hw_mask` is. The address still advances. In linear mode freeze is ignored.
- R12: If either the row size or the row count is zero, the window is empty: `addr` stays at the start and `commit` stays low.
- R13: On a cycle with `port_en` low and no pointer reset, `addr` holds its value.
- R14: When `WR_SIDE`=0, the row step is the low 12 bits of `cfg_stride`, read as an unsigned number, and the mirror and freeze inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous global reset, active low |
| port_rst | input | 1 | Pointer reset; captures configuration |
| port_en | input | 1 | Access enable; advances the address |
| hw_mask | input | 1 | Hardware write mask (linear mode only) |
| cfg_win_en | input | 1 | Window mode select |
| cfg_mirror | input | 1 | Reverse each row |
| cfg_freeze | input | 1 | Block writes in window mode |
| cfg_start | input | 13 | Window origin block |
| cfg_xsize | input | 10 | Row size in blocks |
| cfg_stride | input | 13 | Row step in blocks |
| cfg_ysize | input | 16 | Row count |
| addr | output | 19 | Byte address of the current access |
| commit | output | 1 | Current enabled cycle stores data |

## Verification
`addr` is a register. It shows the address of the access that the next rising edge performs, and it changes only at that edge. `commit` is combinational from `port_en`, `port_rst` and the captured settings, so it is valid within the same cycle. The bench drives inputs on the falling edge and samples both outputs one time step later. At that moment `addr` holds the value for access k, which the bench compares against a reference formula for row r and column c. A configuration captured on a reset edge is seen from the next sample onward.

// File: rtl/swag_pkg.sv
package swag_pkg;
  localparam int DEF_BLK_W  = 13;
  localparam int DEF_BYTE_W = 6;
  localparam int DEF_XSZ_W  = 10;
  localparam int DEF_YSZ_W  = 16;
  localparam int DEF_STR_W  = 13;

  typedef enum logic {
    STEP_UP   = 1'b0,
    STEP_DOWN = 1'b1
  } step_dir_e;
endpackage

// File: rtl/swag_shadow.sv
module swag_shadow #(
  parameter int BLK_W   = swag_pkg::DEF_BLK_W,
  parameter int BYTE_W  = swag_pkg::DEF_BYTE_W,
  parameter int XSZ_W   = swag_pkg::DEF_XSZ_W,
  parameter int YSZ_W   = swag_pkg::DEF_YSZ_W,
  parameter int STR_W   = swag_pkg::DEF_STR_W,
  parameter bit WR_SIDE = 1'b1,
  localparam int ADDR_W = BLK_W + BYTE_W,
  localparam int ROW_W  = XSZ_W + BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              cfg_win_en,
  input  logic              cfg_mirror,
  input  logic              cfg_freeze,
  input  logic [BLK_W-1:0]  cfg_start,
  input  logic [XSZ_W-1:0]  cfg_xsize,
  input  logic [STR_W-1:0]  cfg_stride,
  input  logic [YSZ_W-1:0]  cfg_ysize,
  output logic [ADDR_W-1:0] ld_start_b,
  output logic              sh_en,
  output swag_pkg::step_dir_e sh_dir,
  output logic              sh_freeze,
  output logic              sh_empty,
  output logic [ADDR_W-1:0] sh_start_b,
  output logic [ADDR_W-1:0] sh_step_b,
  output logic [ROW_W-1:0]  sh_rowlen,
  output logic [YSZ_W-1:0]  sh_ysize
);
  localparam int EXT_W = ADDR_W + STR_W;

  logic [EXT_W-1:0] step_ext;
  logic             mirror_eff;
  logic             freeze_eff;

  assign ld_start_b = {cfg_start, {BYTE_W{1'b0}}};

  generate
    if (WR_SIDE) begin : g_wr
      assign step_ext   = {{ADDR_W{cfg_stride[STR_W-1]}}, cfg_stride};
      assign mirror_eff = cfg_mirror;
      assign freeze_eff = cfg_freeze;
    end else begin : g_rd
      assign step_ext   = {{(ADDR_W+1){1'b0}}, cfg_stride[STR_W-2:0]};
      assign mirror_eff = 1'b0;
      assign freeze_eff = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_en      <= 1'b0;
      sh_dir     <= swag_pkg::STEP_UP;
      sh_freeze  <= 1'b0;
      sh_empty   <= 1'b1;
      sh_start_b <= '0;
      sh_step_b  <= '0;
      sh_rowlen  <= '0;
      sh_ysize   <= '0;
    end else if (load) begin
      sh_en      <= cfg_win_en;
      sh_dir     <= mirror_eff ? swag_pkg::STEP_DOWN : swag_pkg::STEP_UP;
      sh_freeze  <= freeze_eff;
      sh_empty   <= (cfg_xsize == '0) || (cfg_ysize == '0);
      sh_start_b <= ld_start_b;
      sh_step_b  <= {step_ext[BLK_W-1:0], {BYTE_W{1'b0}}};
      sh_rowlen  <= {cfg_xsize, {BYTE_W{1'b0}}};
      sh_ysize   <= cfg_ysize;
    end
  end
endmodule

// File: rtl/swag_walker.sv
module swag_walker #(
  parameter int ADDR_W = 19,
  parameter int ROW_W  = 16,
  parameter int YSZ_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [ADDR_W-1:0] restart_b,
  input  logic              advance,
  input  swag_pkg::step_dir_e dir,
  input  logic [ADDR_W-1:0] start_b,
  input  logic [ADDR_W-1:0] step_b,
  input  logic [ROW_W-1:0]  rowlen,
  input  logic [YSZ_W-1:0]  ysize,
  output logic [ADDR_W-1:0] waddr
);
  logic [ROW_W-1:0]  col_q;
  logic [YSZ_W-1:0]  row_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] next_base;
  logic              col_end;
  logic              row_end;

  assign col_end   = (col_q == rowlen - 1'b1);
  assign row_end   = (row_q == ysize - 1'b1);
  assign next_base = base_q + step_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      row_q  <= '0;
      base_q <= '0;
      waddr  <= '0;
    end else if (restart) begin
      col_q  <= '0;
      row_q  <= '0;
      base_q <= restart_b;
      waddr  <= restart_b;
    end else if (advance) begin
      if (col_end) begin
        col_q <= '0;
        if (row_end) begin
          row_q  <= '0;
          base_q <= start_b;
          waddr  <= start_b;
        end else begin
          row_q  <= row_q + 1'b1;
          base_q <= next_base;
          waddr  <= next_base;
        end
      end else begin
        col_q <= col_q + 1'b1;
        waddr <= (dir == swag_pkg::STEP_DOWN) ? waddr - 1'b1 : waddr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/swag_linear.sv
module swag_linear #(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  output logic [ADDR_W-1:0] laddr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     laddr <= '0;
    else if (clear) laddr <= '0;
    else if (step)  laddr <= laddr + 1'b1;
  end
endmodule

// File: rtl/swag_commit.sv
module swag_commit (
  input  logic port_en,
  input  logic port_rst,
  input  logic hw_mask,
  input  logic win_on,
  input  logic win_freeze,
  input  logic win_empty,
  output logic commit
);
  logic allow;

  always_comb begin
    if (win_on) allow = !win_freeze && !win_empty;
    else        allow = !hw_mask;
    commit = port_en && !port_rst && allow;
  end
endmodule

// File: rtl/strided_win_agen.sv
module strided_win_agen #(
  parameter int BLK_W   = swag_pkg::DEF_BLK_W,
  parameter int BYTE_W  = swag_pkg::DEF_BYTE_W,
  parameter int XSZ_W   = swag_pkg::DEF_XSZ_W,
  parameter int YSZ_W   = swag_pkg::DEF_YSZ_W,
  parameter int STR_W   = swag_pkg::DEF_STR_W,
  parameter bit WR_SIDE = 1'b1,
  localparam int ADDR_W = BLK_W + BYTE_W,
  localparam int ROW_W  = XSZ_W + BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_rst,
  input  logic              port_en,
  input  logic              hw_mask,
  input  logic              cfg_win_en,
  input  logic              cfg_mirror,
  input  logic              cfg_freeze,
  input  logic [BLK_W-1:0]  cfg_start,
  input  logic [XSZ_W-1:0]  cfg_xsize,
  input  logic [STR_W-1:0]  cfg_stride,
  input  logic [YSZ_W-1:0]  cfg_ysize,
  output logic [ADDR_W-1:0] addr,
  output logic              commit
);
  logic [ADDR_W-1:0]   ld_start_b;
  logic                win_on;
  swag_pkg::step_dir_e win_dir;
  logic                win_freeze;
  logic                win_empty;
  logic [ADDR_W-1:0]   win_start_b;
  logic [ADDR_W-1:0]   win_step_b;
  logic [ROW_W-1:0]    win_rowlen;
  logic [YSZ_W-1:0]    win_ysize;
  logic [ADDR_W-1:0]   waddr;
  logic [ADDR_W-1:0]   laddr;
  logic                win_adv;

  swag_shadow #(
    .BLK_W(BLK_W), .BYTE_W(BYTE_W), .XSZ_W(XSZ_W), .YSZ_W(YSZ_W),
    .STR_W(STR_W), .WR_SIDE(WR_SIDE)
  ) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(port_rst),
    .cfg_win_en(cfg_win_en), .cfg_mirror(cfg_mirror), .cfg_freeze(cfg_freeze),
    .cfg_start(cfg_start), .cfg_xsize(cfg_xsize), .cfg_stride(cfg_stride),
    .cfg_ysize(cfg_ysize), .ld_start_b(ld_start_b),
    .sh_en(win_on), .sh_dir(win_dir), .sh_freeze(win_freeze),
    .sh_empty(win_empty), .sh_start_b(win_start_b), .sh_step_b(win_step_b),
    .sh_rowlen(win_rowlen), .sh_ysize(win_ysize)
  );

  assign win_adv = port_en && !port_rst && win_on && !win_empty;

  swag_walker #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .YSZ_W(YSZ_W)) u_walker (
    .clk(clk), .rst_n(rst_n), .restart(port_rst), .restart_b(ld_start_b),
    .advance(win_adv), .dir(win_dir), .start_b(win_start_b),
    .step_b(win_step_b), .rowlen(win_rowlen), .ysize(win_ysize),
    .waddr(waddr)
  );

  swag_linear #(.ADDR_W(ADDR_W)) u_linear (
    .clk(clk), .rst_n(rst_n), .clear(port_rst), .step(port_en),
    .laddr(laddr)
  );

  swag_commit u_commit (
    .port_en(port_en), .port_rst(port_rst), .hw_mask(hw_mask),
    .win_on(win_on), .win_freeze(win_freeze), .win_empty(win_empty),
    .commit(commit)
  );

  assign addr = win_on ? waddr : laddr;
endmodule

// File: rtl/swag_chk.sv
module swag_chk #(
  parameter int BLK_W  = 13,
  parameter int ADDR_W = 19,
  parameter int BYTE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              port_rst,
  input logic              port_en,
  input logic              cfg_win_en,
  input logic [BLK_W-1:0]  cfg_start,
  input logic              win_on,
  input logic              win_empty,
  input logic [ADDR_W-1:0] addr,
  input logic              commit
);
  p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_en && !port_rst) |=> $stable(addr));

  p_lin_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (port_rst && !cfg_win_en) |=> (addr == '0));

  p_lin_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_on && port_en && !port_rst) |=> (addr == $past(addr) + 1'b1));

  p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (port_rst && cfg_win_en) |=> (addr == {$past(cfg_start), {BYTE_W{1'b0}}}));

  p_rst_nocommit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    port_rst |-> !commit);

  p_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (win_on && win_empty && !port_rst) |=> $stable(addr));
endmodule

bind strided_win_agen swag_chk #(
  .BLK_W(BLK_W), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)
) u_swag_chk (
  .clk(clk), .rst_n(rst_n), .port_rst(port_rst), .port_en(port_en),
  .cfg_win_en(cfg_win_en), .cfg_start(cfg_start), .win_on(win_on),
  .win_empty(win_empty), .addr(addr), .commit(commit)
);

// File: tb/test_strided_win_agen.sv
`timescale 1ns/1ps
module test_strided_win_agen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        port_rst = 1'b0, port_en = 1'b0, hw_mask = 1'b0;
  logic        cfg_win_en = 1'b0, cfg_mirror = 1'b0, cfg_freeze = 1'b0;
  logic [12:0] cfg_start = '0;
  logic [9:0]  cfg_xsize = '0;
  logic [12:0] cfg_stride = '0;
  logic [15:0] cfg_ysize = '0;
  logic [18:0] addr_w, addr_r;
  logic        commit_w, commit_r;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  strided_win_agen i_strided_win_agen (
    .clk(clk), .rst_n(rst_n), .port_rst(port_rst), .port_en(port_en),
    .hw_mask(hw_mask), .cfg_win_en(cfg_win_en), .cfg_mirror(cfg_mirror),
    .cfg_freeze(cfg_freeze), .cfg_start(cfg_start), .cfg_xsize(cfg_xsize),
    .cfg_stride(cfg_stride), .cfg_ysize(cfg_ysize), .addr(addr_w),
    .commit(commit_w));

  strided_win_agen #(.WR_SIDE(1'b0)) i_strided_win_agen_rd (
    .clk(clk), .rst_n(rst_n), .port_rst(port_rst), .port_en(port_en),
    .hw_mask(hw_mask), .cfg_win_en(cfg_win_en), .cfg_mirror(cfg_mirror),
    .cfg_freeze(cfg_freeze), .cfg_start(cfg_start), .cfg_xsize(cfg_xsize),
    .cfg_stride(cfg_stride), .cfg_ysize(cfg_ysize), .addr(addr_r),
    .commit(commit_r));

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint model(int start, int xs, int stride, int ys,
                                   bit mir, int k);
    longint rl, tot, kk, r, c, a;
    rl  = longint'(xs) * 64;
    tot = rl * ys;
    if (tot == 0) return longint'(start) * 64;
    kk = k % tot;
    r  = kk / rl;
    c  = kk % rl;
    a  = longint'(start) * 64 + r * stride * 64 + (mir ? -c : c);
    a  = ((a % 524288) + 524288) % 524288;
    return a;
  endfunction

  task automatic prst();
    port_en  = 1'b0;
    port_rst = 1'b1;
    #1 chk("R4 commit low on pointer reset", commit_w, 0);
    @(negedge clk);
    port_rst = 1'b0;
  endtask

  task automatic set_cfg(bit we, bit mi, bit fr, int st, int xs, int sd, int ys);
    cfg_win_en = we; cfg_mirror = mi; cfg_freeze = fr;
    cfg_start = 13'(st); cfg_xsize = 10'(xs);
    cfg_stride = 13'(sd); cfg_ysize = 16'(ys);
  endtask

  task automatic walk(string req, bit rd, int st, int xs, int sd, int ys,
                      bit mi, int n);
    for (int k = 0; k < n; k++) begin
      port_en = 1'b1;
      #1 chk(req, rd ? addr_r : addr_w, model(st, xs, sd, ys, mi, k));
      @(negedge clk);
    end
    port_en = 1'b0;
  endtask

  task automatic t_reset();
    #1 chk("R1 addr after reset", addr_w, 0);
    chk("R1 commit after reset", commit_w, 0);
  endtask

  task automatic t_linear();
    set_cfg(0, 0, 0, 0, 0, 0, 0);
    prst();
    for (int k = 0; k < 5; k++) begin
      port_en = 1'b1; hw_mask = k[0];
      #1 chk("R2 linear addr", addr_w, k);
      chk("R2 linear commit", commit_w, !k[0]);
      @(negedge clk);
    end
    port_en = 1'b0; hw_mask = 1'b0;
    @(negedge clk);
    #1 chk("R13 hold without enable", addr_w, 5);
    @(negedge clk);
  endtask

  task automatic t_window_up();
    set_cfg(1, 0, 0, 10, 1, 3, 2);
    prst();
    set_cfg(1, 1, 1, 99, 3, -7, 4);   // R3: no effect until next reset
    walk("R5 R6 R9 R3 ascending walk", 0, 10, 1, 3, 2, 0, 130);
    prst();
    #1 chk("R3 new start after reset", addr_w, 99 * 64);
    @(negedge clk);
  endtask

  task automatic t_mirror_neg();
    set_cfg(1, 1, 0, 100, 2, -5, 3);
    prst();
    walk("R7 R8 R9 mirror with negative step", 0, 100, 2, -5, 3, 1, 390);
  endtask

  task automatic t_wrap();
    set_cfg(1, 0, 0, 8191, 2, 1, 1);
    prst();
    walk("R10 modulo wrap", 0, 8191, 2, 1, 1, 0, 130);
  endtask

  task automatic t_freeze();
    set_cfg(1, 0, 1, 5, 1, 0, 1);
    prst();
    port_en = 1'b1; hw_mask = 1'b0;
    #1 chk("R11 freeze blocks commit", commit_w, 0);
    @(negedge clk);
    #1 chk("R11 address advances while frozen", addr_w, 5 * 64 + 1);
    cfg_freeze = 1'b0;
    #1 chk("R3 freeze change ignored without reset", commit_w, 0);
    prst();
    port_en = 1'b1; hw_mask = 1'b1;
    #1 chk("R11 window ignores hw_mask", commit_w, 1);
    @(negedge clk);
    set_cfg(0, 0, 1, 5, 1, 0, 1);
    prst();
    port_en = 1'b1; hw_mask = 1'b0;
    #1 chk("R11 freeze ignored in linear mode", commit_w, 1);
    hw_mask = 1'b1;
    #1 chk("R2 hw_mask in linear mode", commit_w, 0);
    @(negedge clk);
    port_en = 1'b0; hw_mask = 1'b0;
  endtask

  task automatic t_empty();
    set_cfg(1, 0, 0, 7, 0, 1, 3);
    prst();
    for (int k = 0; k < 4; k++) begin
      port_en = 1'b1;
      #1 chk("R12 zero row size addr", addr_w, 7 * 64);
      chk("R12 zero row size commit", commit_w, 0);
      @(negedge clk);
    end
    set_cfg(1, 0, 0, 9, 2, 1, 0);
    prst();
    for (int k = 0; k < 4; k++) begin
      port_en = 1'b1;
      #1 chk("R12 zero row count addr", addr_w, 9 * 64);
      chk("R12 zero row count commit", commit_w, 0);
      @(negedge clk);
    end
    port_en = 1'b0;
  endtask

  task automatic t_read_variant();
    set_cfg(1, 1, 1, 100, 1, 13'h1FFB, 2);
    prst();
    port_en = 1'b1;
    #1 chk("R14 read side ignores freeze", commit_r, 1);
    walk("R14 read side unsigned step no mirror", 1, 100, 1, 4091, 2, 0, 130);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_linear();
    t_window_up();
    t_mirror_neg();
    t_wrap();
    t_freeze();
    t_empty();
    t_read_variant();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule